// File: doc/BRIEF.md
# Tributary pointer and stuff generator

This block sits in the transmit low-order path of a SONET/SDH mapper. It serves one VT1.5 or VT2 tributary. Once per superframe it builds the 16-bit pointer word that goes into the V1/V2 bytes. In the same step it decides whether the container carries a positive bit stuff, a negative bit stuff or no stuff.

There are three modes, set on `mode`:
- **Asynchronous:** the pointer stays at its fixed offset. The stuff decision follows the fill level of the elastic store that feeds the tributary.
- **Bit-synchronous:** the pointer stays at its fixed offset and stuffing is switched off.
- **Byte-synchronous:** the block follows the position of the path overhead marker byte, given as an offset. It emits normal pointers, one-step increments and decrements, or a new-data pointer when the marker jumps. A hold-off spaces the adjustments apart.

The surrounding frame logic pulses `sf_tick` once per superframe and takes the registered result from the next cycle. That logic also does the byte multiplexing and the overhead insertion.

Top module: `vtp_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `ptr_word` is 0, `ptr_act` is 0, `stuff` is 0 and `ptr_vld` is 0.
- R2: Each `sf_tick` pulse produces exactly one result, which is registered on that clock edge. `ptr_vld` is high for exactly the cycle after the tick. `ptr_word`, `ptr_act` and `stuff` hold their values until the next tick.
- R3: The pointer word is {NDF[15:12], size[11:10], offset[9:0]}. NDF is 4'b1001 when `ptr_act` is new-data, and 4'b0110 otherwise. Size is 2'b11 when `vt_size`=0 (VT1.5) and 2'b10 when `vt_size`=1 (VT2).
- R4: `mode` bit 1 selects the mode: 0 gives a fixed-pointer mode, 1 gives byte-synchronous. Within the fixed-pointer modes, `mode`=2'b00 is asynchronous and 2'b01 is bit-synchronous. In the fixed-pointer modes every result has `ptr_act`=0 (normal) and offset 78 for VT1.5 or 105 for VT2.
- R5: In asynchronous mode, `stuff` is 2'b01 (positive) when `fill` < FILL_LO. It is 2'b10 (negative) when `fill` > FILL_HI, and 2'b00 (null) otherwise.
- R6: In bit-synchronous and byte-synchronous mode, `stuff` is always 2'b00 (null), whatever the value of `fill`.
- R7: In byte-synchronous mode, when `marker` equals the current offset, the result is a normal pointer (`ptr_act`=2'b00) that carries the current offset.
- R8: When `marker` is one above the current offset and adjustments are allowed, the result is an increment (`ptr_act`=2'b10). The word carries the old offset with its I bits inverted; the I bits are the odd-numbered offset bits 9,7,5,3,1. From then on the current offset is the marker value.
- R9: When `marker` is one below the current offset and adjustments are allowed, the result is a decrement (`ptr_act`=2'b11). The word carries the old offset with its D bits inverted; the D bits are the even-numbered offset bits 8,6,4,2,0. From then on the current offset is the marker value.
- R10: When adjustments are allowed and `marker` differs from the current offset by more than one step, the result is a new-data pointer (`ptr_act`=2'b01) that carries `marker` as the offset. From then on the current offset is `marker`.
- R11: After an increment, a decrement or a new-data pointer, the next HOLD_SF (3) results are normal pointers with the current offset, whatever `marker` is. The following result may adjust again. Leaving byte-synchronous mode resets the current offset to the fixed value and clears the hold-off.
- R12: Offsets wrap within 0..103 for VT1.5 and 0..139 for VT2. An increment from the top value goes to 0, and a decrement from 0 goes to the top value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sf_tick | input | 1 | One-cycle pulse once per superframe that requests a result |
| mode | input | 2 | 00 asynchronous, 01 bit-synchronous, 1x byte-synchronous |
| vt_size | input | 1 | 0 = VT1.5, 1 = VT2 |
| marker | input | 10 | Offset of the path overhead marker byte (byte-synchronous mode) |
| fill | input | FILL_W | Elastic store fill level in bits |
| ptr_word | output | 16 | Pointer word for V1/V2 |
| ptr_act | output | 2 | Pointer action: 00 normal, 01 new data, 10 increment, 11 decrement |
| stuff | output | 2 | Stuff decision: 00 null, 01 positive, 10 negative |
| ptr_vld | output | 1 | High for one cycle when a new result is presented |

## Verification
Every result is due on the first rising edge after the cycle in which `sf_tick` is high. It can therefore be seen one cycle after the pulse, together with `ptr_vld`. The bench drives the tick at a falling edge and samples all outputs at the next falling edge. It then waits one to three idle cycles and samples again, to show that the result is held and that `ptr_vld` is low. The bench keeps its own record of the current offset and of the hold-off. It updates that record only after it has compared a result, so the state it uses for each expected value is the state the design had before that tick.

// File: rtl/vtp_pkg.sv
package vtp_pkg;

  localparam int OFF_W = 10;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    ACT_NORM = 2'b00,
    ACT_NDF  = 2'b01,
    ACT_INC  = 2'b10,
    ACT_DEC  = 2'b11
  } ptr_act_e;

  typedef enum logic [1:0] {
    STF_NULL = 2'b00,
    STF_POS  = 2'b01,
    STF_NEG  = 2'b10
  } stuff_e;

  localparam logic [3:0] NDF_NORMAL = 4'b0110;
  localparam logic [3:0] NDF_NEWDAT = 4'b1001;

  // highest legal offset for the selected tributary size
  function automatic logic [OFF_W-1:0] off_limit(input logic big);
    return big ? 10'd139 : 10'd103;
  endfunction

  // offset used when the pointer is not tracking a marker
  function automatic logic [OFF_W-1:0] fixed_off(input logic big);
    return big ? 10'd105 : 10'd78;
  endfunction

endpackage

// File: rtl/vtp_stuff_sel.sv
module vtp_stuff_sel
  import vtp_pkg::*;
#(
  parameter int FILL_W  = 7,
  parameter int FILL_LO = 24,
  parameter int FILL_HI = 40
) (
  input  logic              async_en,
  input  logic [FILL_W-1:0] fill,
  output stuff_e            stuff_o
);

  localparam logic [FILL_W-1:0] LO_V = FILL_W'(FILL_LO);
  localparam logic [FILL_W-1:0] HI_V = FILL_W'(FILL_HI);

  always_comb begin
    stuff_o = STF_NULL;
    if (async_en) begin
      if (fill < LO_V)      stuff_o = STF_POS;
      else if (fill > HI_V) stuff_o = STF_NEG;
    end
  end

endmodule

// File: rtl/vtp_ptr_track.sv
module vtp_ptr_track
  import vtp_pkg::*;
#(
  parameter int HOLD_SF = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             byte_mode,
  input  logic             vt_size,
  input  logic [OFF_W-1:0] marker,
  output ptr_act_e         act_o,
  output logic [OFF_W-1:0] off_o
);

  localparam int HW = (HOLD_SF < 1) ? 1 : $clog2(HOLD_SF + 1);

  logic [OFF_W-1:0] cur_q;
  logic [HW-1:0]    hold_q;
  logic [OFF_W-1:0] lim;
  logic [OFF_W-1:0] nxt_up;
  logic [OFF_W-1:0] nxt_dn;

  assign lim    = off_limit(vt_size);
  assign nxt_up = (cur_q >= lim) ? '0 : cur_q + 10'd1;
  assign nxt_dn = (cur_q == '0) ? lim : cur_q - 10'd1;

  always_comb begin
    act_o = ACT_NORM;
    off_o = cur_q;
    if (marker != cur_q && hold_q == '0) begin
      if (marker == nxt_up) begin
        act_o = ACT_INC;
      end else if (marker == nxt_dn) begin
        act_o = ACT_DEC;
      end else begin
        act_o = ACT_NDF;
        off_o = marker;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      hold_q <= '0;
    end else if (!byte_mode) begin
      cur_q  <= fixed_off(vt_size);
      hold_q <= '0;
    end else if (tick) begin
      if (act_o != ACT_NORM) begin
        cur_q  <= marker;
        hold_q <= HW'(HOLD_SF);
      end else if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/vtp_word_enc.sv
module vtp_word_enc
  import vtp_pkg::*;
(
  input  ptr_act_e          act,
  input  logic              vt_size,
  input  logic [OFF_W-1:0]  off,
  output logic [WORD_W-1:0] word_o
);

  logic [OFF_W-1:0] i_mask;
  logic [OFF_W-1:0] d_mask;
  logic [OFF_W-1:0] flip;

  for (genvar b = 0; b < OFF_W; b++) begin : g_mask
    assign i_mask[b] = (b % 2) == 1;
    assign d_mask[b] = (b % 2) == 0;
  end

  always_comb begin
    case (act)
      ACT_INC: flip = i_mask;
      ACT_DEC: flip = d_mask;
      default: flip = '0;
    endcase
  end

  assign word_o = {(act == ACT_NDF) ? NDF_NEWDAT : NDF_NORMAL,
                   vt_size ? 2'b10 : 2'b11,
                   off ^ flip};

endmodule

// File: rtl/vtp_gen.sv
module vtp_gen
  import vtp_pkg::*;
#(
  parameter int FILL_W  = 7,
  parameter int FILL_LO = 24,
  parameter int FILL_HI = 40,
  parameter int HOLD_SF = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sf_tick,
  input  logic [1:0]        mode,
  input  logic              vt_size,
  input  logic [OFF_W-1:0]  marker,
  input  logic [FILL_W-1:0] fill,
  output logic [WORD_W-1:0] ptr_word,
  output logic [1:0]        ptr_act,
  output logic [1:0]        stuff,
  output logic              ptr_vld
);

  logic             byte_mode;
  logic             async_en;
  ptr_act_e         trk_act;
  logic [OFF_W-1:0] trk_off;
  ptr_act_e         sel_act;
  logic [OFF_W-1:0] sel_off;
  stuff_e           stf_d;
  logic [WORD_W-1:0] word_d;

  assign byte_mode = mode[1];
  assign async_en  = (mode == 2'b00);

  vtp_ptr_track #(.HOLD_SF(HOLD_SF)) trk_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (sf_tick),
    .byte_mode (byte_mode),
    .vt_size   (vt_size),
    .marker    (marker),
    .act_o     (trk_act),
    .off_o     (trk_off)
  );

  vtp_stuff_sel #(.FILL_W(FILL_W), .FILL_LO(FILL_LO), .FILL_HI(FILL_HI)) stf_i (
    .async_en (async_en),
    .fill     (fill),
    .stuff_o  (stf_d)
  );

  assign sel_act = byte_mode ? trk_act : ACT_NORM;
  assign sel_off = byte_mode ? trk_off : fixed_off(vt_size);

  vtp_word_enc enc_i (
    .act     (sel_act),
    .vt_size (vt_size),
    .off     (sel_off),
    .word_o  (word_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_word <= '0;
      ptr_act  <= 2'b00;
      stuff    <= 2'b00;
      ptr_vld  <= 1'b0;
    end else begin
      ptr_vld <= sf_tick;
      if (sf_tick) begin
        ptr_word <= word_d;
        ptr_act  <= sel_act;
        stuff    <= stf_d;
      end
    end
  end

endmodule

// File: rtl/vtp_gen_chk.sv
module vtp_gen_chk #(
  parameter int FILL_W  = 7,
  parameter int FILL_LO = 24,
  parameter int FILL_HI = 40,
  parameter int HOLD_SF = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              sf_tick,
  input logic [1:0]        mode,
  input logic              vt_size,
  input logic [FILL_W-1:0] fill,
  input logic [15:0]       ptr_word,
  input logic [1:0]        ptr_act,
  input logic [1:0]        stuff,
  input logic              ptr_vld
);

  localparam int CW = (HOLD_SF < 1) ? 1 : $clog2(HOLD_SF + 1);

  logic [CW-1:0] norm_cnt;
  logic          adj_seen;

  always_ff @(posedge clk) begin
    if (rst || !mode[1]) begin
      norm_cnt <= '0;
      adj_seen <= 1'b0;
    end else if (ptr_vld) begin
      if (ptr_act != 2'b00) begin
        adj_seen <= 1'b1;
        norm_cnt <= '0;
      end else if (norm_cnt < CW'(HOLD_SF)) begin
        norm_cnt <= norm_cnt + 1'b1;
      end
    end
  end

  AST_VLD_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (rst)
    sf_tick |=> ptr_vld); // R2
  AST_NO_SPURIOUS_VLD: assert property (@(posedge clk) disable iff (rst)
    !sf_tick |=> !ptr_vld); // R2
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !sf_tick |=> ($stable(ptr_word) && $stable(ptr_act) && $stable(stuff))); // R2
  AST_SIZE_FIELD: assert property (@(posedge clk) disable iff (rst)
    sf_tick |=> ptr_word[11:10] == ($past(vt_size) ? 2'b10 : 2'b11)); // R3
  AST_NDF_CODE: assert property (@(posedge clk) disable iff (rst)
    ptr_vld |-> ptr_word[15:12] == ((ptr_act == 2'b01) ? 4'b1001 : 4'b0110)); // R3
  AST_FIXED_PTR: assert property (@(posedge clk) disable iff (rst)
    (sf_tick && !mode[1]) |=>
      (ptr_act == 2'b00 && ptr_word[9:0] == ($past(vt_size) ? 10'd105 : 10'd78))); // R4
  AST_POS_STUFF: assert property (@(posedge clk) disable iff (rst)
    (sf_tick && mode == 2'b00 && fill < FILL_W'(FILL_LO)) |=> stuff == 2'b01); // R5
  AST_NEG_STUFF: assert property (@(posedge clk) disable iff (rst)
    (sf_tick && mode == 2'b00 && fill > FILL_W'(FILL_HI)) |=> stuff == 2'b10); // R5
  AST_NULL_STUFF: assert property (@(posedge clk) disable iff (rst)
    (sf_tick && mode != 2'b00) |=> stuff == 2'b00); // R6
  AST_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
    (ptr_vld && mode[1] && ptr_act != 2'b00) |-> (!adj_seen || norm_cnt >= CW'(HOLD_SF))); // R11

endmodule

bind vtp_gen vtp_gen_chk #(
  .FILL_W(FILL_W), .FILL_LO(FILL_LO), .FILL_HI(FILL_HI), .HOLD_SF(HOLD_SF)
) chk_i (.*);

// File: tb/vtp_gen_tb_top.sv
`timescale 1ns/1ps
module vtp_gen_tb_top;

  localparam int FILL_W  = 7;
  localparam int FILL_LO = 24;
  localparam int FILL_HI = 40;
  localparam int HOLD_SF = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sf_tick = 1'b0;
  logic [1:0]        mode = 2'b00;
  logic              vt_size = 1'b0;
  logic [9:0]        marker = '0;
  logic [FILL_W-1:0] fill = '0;
  logic [15:0]       ptr_word;
  logic [1:0]        ptr_act;
  logic [1:0]        stuff;
  logic              ptr_vld;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // bench record of the tracker state
  logic [9:0] m_cur = '0;
  int         m_hold = 0;

  always #2.5 clk = ~clk;

  vtp_gen #(.FILL_W(FILL_W), .FILL_LO(FILL_LO), .FILL_HI(FILL_HI), .HOLD_SF(HOLD_SF)) dut_i (
    .clk(clk), .rst(rst), .sf_tick(sf_tick), .mode(mode), .vt_size(vt_size),
    .marker(marker), .fill(fill), .ptr_word(ptr_word), .ptr_act(ptr_act),
    .stuff(stuff), .ptr_vld(ptr_vld)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [9:0] lim_of(input logic sz);
    return sz ? 10'd139 : 10'd103;
  endfunction

  function automatic logic [9:0] fix_of(input logic sz);
    return sz ? 10'd105 : 10'd78;
  endfunction

  // one superframe: drive, wait one edge, compare with expected, then idle
  task automatic do_sf(input logic [1:0] md, input logic sz, input logic [9:0] mk, input logic [FILL_W-1:0] fl);
    logic [1:0]  e_act;
    logic [1:0]  e_stf;
    logic [9:0]  e_off;
    logic [9:0]  nxt;
    logic [9:0]  lim;
    logic [15:0] e_word;
    logic [15:0] held;
    string       tag;
    int          gap;
    lim = lim_of(sz);
    if (!md[1]) begin
      m_cur = fix_of(sz);
      m_hold = 0;
      e_act = 2'b00; e_off = m_cur; nxt = m_cur; tag = "R4";
    end else if (mk == m_cur) begin
      e_act = 2'b00; e_off = m_cur; nxt = m_cur; tag = "R7";
    end else if (m_hold != 0) begin
      e_act = 2'b00; e_off = m_cur; nxt = m_cur; tag = "R11";
    end else if (mk == ((m_cur >= lim) ? 10'd0 : m_cur + 10'd1)) begin
      e_act = 2'b10; e_off = m_cur ^ 10'b10_1010_1010; nxt = mk;
      tag = (m_cur == lim) ? "R12" : "R8";
    end else if (mk == ((m_cur == 10'd0) ? lim : m_cur - 10'd1)) begin
      e_act = 2'b11; e_off = m_cur ^ 10'b01_0101_0101; nxt = mk;
      tag = (m_cur == 10'd0) ? "R12" : "R9";
    end else begin
      e_act = 2'b01; e_off = mk; nxt = mk; tag = "R10";
    end
    if (md == 2'b00) e_stf = (fl < FILL_LO) ? 2'b01 : ((fl > FILL_HI) ? 2'b10 : 2'b00);
    else             e_stf = 2'b00;
    e_word = {(e_act == 2'b01) ? 4'b1001 : 4'b0110, sz ? 2'b10 : 2'b11, e_off};

    @(negedge clk);
    mode = md; vt_size = sz; marker = mk; fill = fl; sf_tick = 1'b1;
    @(negedge clk);
    sf_tick = 1'b0;
    chk("R2", "vld after tick", ptr_vld, 1);
    chk(tag, "pointer word", ptr_word, e_word);
    chk(tag, "pointer action", ptr_act, e_act);
    chk("R3", "size field", ptr_word[11:10], sz ? 2'b10 : 2'b11);
    chk((md == 2'b00) ? "R5" : "R6", "stuff", stuff, e_stf);

    if (md[1]) begin
      if (e_act != 2'b00) m_hold = HOLD_SF;
      else if (m_hold != 0) m_hold--;
      m_cur = nxt;
    end

    held = ptr_word;
    gap = 1 + int'($urandom % 3);
    fill = FILL_W'($urandom % 65);
    for (int g = 0; g < gap; g++) @(negedge clk);
    chk("R2", "vld idle", ptr_vld, 0);
    chk("R2", "word held", ptr_word, held);
  endtask

  function automatic logic [9:0] step(input logic [9:0] c, input logic sz, input int kind);
    logic [9:0] lim;
    lim = lim_of(sz);
    case (kind)
      1: return (c >= lim) ? 10'd0 : c + 10'd1;
      2: return (c == 10'd0) ? lim : c - 10'd1;
      3: return 10'($urandom % (32'(lim) + 1));
      default: return c;
    endcase
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20251);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "word in reset", ptr_word, 0);
    chk("R1", "vld in reset", ptr_vld, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "word after reset", ptr_word, 0);
    chk("R1", "act after reset", ptr_act, 0);
    chk("R1", "stuff after reset", stuff, 0);
    chk("R1", "vld after reset", ptr_vld, 0);

    // R5 thresholds, R6 null in bit-sync, R4 fixed pointers
    do_sf(2'b00, 1'b0, 10'd0, 7'(FILL_LO - 1));
    do_sf(2'b00, 1'b0, 10'd0, 7'(FILL_LO));
    do_sf(2'b00, 1'b1, 10'd0, 7'(FILL_HI));
    do_sf(2'b00, 1'b1, 10'd0, 7'(FILL_HI + 1));
    do_sf(2'b01, 1'b1, 10'd0, 7'd0);
    do_sf(2'b01, 1'b0, 10'd0, 7'd64);

    // directed wrap and hold-off for both sizes (R10, R11, R12, R8, R9, R7)
    for (int s = 0; s < 2; s++) begin
      logic sz;
      logic [9:0] top;
      sz = s[0];
      top = lim_of(sz);
      do_sf(2'b00, sz, 10'd0, 7'd30);
      do_sf(2'b10, sz, top, 7'd0);          // new data to the top offset
      do_sf(2'b10, sz, 10'd0, 7'd0);        // held off
      do_sf(2'b10, sz, top, 7'd0);
      do_sf(2'b10, sz, top, 7'd0);
      do_sf(2'b10, sz, 10'd0, 7'd0);        // increment wraps to 0
      for (int k = 0; k < HOLD_SF; k++) do_sf(2'b11, sz, 10'd0, 7'd0);
      do_sf(2'b11, sz, top, 7'd0);          // decrement wraps to top
      for (int k = 0; k < HOLD_SF; k++) do_sf(2'b10, sz, top, 7'd0);
      do_sf(2'b10, sz, top - 10'd1, 7'd0);  // plain decrement
      for (int k = 0; k < HOLD_SF; k++) do_sf(2'b10, sz, top - 10'd1, 7'd0);
      do_sf(2'b10, sz, top, 7'd0);          // plain increment
    end

    // constrained random episodes
    for (int ep = 0; ep < 60; ep++) begin
      logic sz;
      logic [9:0] mk;
      sz = 1'($urandom % 2);
      for (int n = 0; n < 1 + int'($urandom % 3); n++)
        do_sf(2'($urandom % 2), sz, 10'($urandom % 1024), FILL_W'($urandom % 65));
      if ($urandom % 2 == 1) begin
        mk = m_cur;
        for (int n = 0; n < 10 + int'($urandom % 10); n++) begin
          mk = step(mk, sz, int'($urandom % 4));
          do_sf({1'b1, 1'($urandom % 2)}, sz, mk, FILL_W'($urandom % 65));
        end
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule